// File: doc/BRIEF.md
# Per-Block Lock Protection Controller

This block holds a protection state for every erase block of a flash array. Each block is open (program and erase allowed), held (locked) or pinned (locked down). Decoded write cycles carry a block index and a data byte. A setup byte arms a two-cycle sequence, and the write cycle after it picks the action for the block it addresses. A pinned block cannot be reopened while the write-protect input is asserted. A second cycle that does not name a known action ends the sequence and raises a two-bit sequence error that feeds two status-register bits.

Program and erase requests are checked against the state of the addressed block. Each request gets either a grant pulse or a lock-error pulse, which feeds the status-register lock-error bit. A combinational read port returns a status word for any block index, for use in identifier reads.

Top module: `blk_lock_ctrl`

## Requirements
- R1: A synchronous reset puts every block into the held state (status word 0x0001) and removes any pinned state.
- R2: Data 0x60 on a write cycle arms the sequence whatever the block index. The next write cycle, of any value, completes it. While not armed, write cycles with other values change no block state and raise no error.
- R3: A second cycle of 0x01 makes the addressed block held. A pinned block stays pinned.
- R4: A second cycle of 0xD0 makes the addressed block open. The exception is a pinned block while `wp` is 1, which keeps its state.
- R5: When `wp` is 0, a second cycle of 0xD0 opens a pinned block.
- R6: A second cycle of 0x2F pins the addressed block. A pinned block can only be left through R5 or through reset.
- R7: Any other second-cycle value leaves all block states unchanged and ends the sequence. `seq_err` reads 2'b11 for exactly the one cycle after that write, and 2'b00 at all other times.
- R8: An `op_req` for an in-range open block gives an `op_ok` pulse in the next cycle.
- R9: An `op_req` for an in-range held or pinned block gives an `op_lock_err` pulse in the next cycle. `op_ok` and `op_lock_err` are never high together.
- R10: `rd_status` for block `rd_blk` is combinational. Bit 0 is 1 when the block is held or pinned, bit 1 is 1 when it is pinned, and all other bits are 0. The values are open 0x0000, held 0x0001 and pinned 0x0003.
- R11: A block index of N_BLK or above changes no state and produces no `op_ok` or `op_lock_err` pulse. It reads back as status 0x0000. A second-cycle value outside 0x01, 0xD0 and 0x2F still raises the R7 error.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_valid | input | 1 | Decoded write cycle strobe |
| wr_blk | input | IDX_W | Block index of the write cycle |
| wr_data | input | 8 | Data byte of the write cycle |
| wp | input | 1 | Write protect; 1 keeps pinned blocks pinned |
| op_req | input | 1 | Program or erase attempt |
| op_blk | input | IDX_W | Block index of the attempt |
| op_ok | output | 1 | Attempt granted (pulse) |
| op_lock_err | output | 1 | Attempt rejected by lock (pulse) |
| seq_err | output | 2 | Sequence error for the two status bits |
| rd_blk | input | IDX_W | Block index for status read |
| rd_status | output | STAT_W | Lock status word of `rd_blk` |

## Verification
The hardest case to reach is a pinned block that receives an unlock. Reaching it needs a full 0x60/0x2F sequence first, then a second full sequence ending in 0xD0, all under a chosen `wp` level. The bench sweeps every block index, including out-of-range ones, across a list of second-cycle codes. It runs the sweep once with `wp` high, so that pins accumulate and have to survive later unlocks, and once with `wp` low, so that the same unlocks open them. After every sequence it reads back all indices and issues a request to the addressed block.

// File: rtl/blk_lock_pkg.sv
package blk_lock_pkg;

    typedef enum logic [1:0] {
        PS_OPEN   = 2'b00,
        PS_HELD   = 2'b01,
        PS_PINNED = 2'b11
    } prot_e;

    typedef enum logic [1:0] {
        ACT_NONE,
        ACT_HOLD,
        ACT_OPEN,
        ACT_PIN
    } act_e;

    localparam logic [7:0] CODE_ARM  = 8'h60;
    localparam logic [7:0] CODE_HOLD = 8'h01;
    localparam logic [7:0] CODE_OPEN = 8'hD0;
    localparam logic [7:0] CODE_PIN  = 8'h2F;

    typedef struct packed {
        act_e act;
        logic bad;
    } decode_t;

    function automatic decode_t decode_second(input logic [7:0] d);
        decode_t r;
        r.bad = 1'b0;
        unique case (d)
            CODE_HOLD: r.act = ACT_HOLD;
            CODE_OPEN: r.act = ACT_OPEN;
            CODE_PIN:  r.act = ACT_PIN;
            default: begin
                r.act = ACT_NONE;
                r.bad = 1'b1;
            end
        endcase
        return r;
    endfunction

    function automatic prot_e next_prot(input prot_e cur, input act_e act, input logic wp);
        prot_e n;
        n = cur;
        unique case (act)
            ACT_HOLD: n = (cur == PS_PINNED) ? PS_PINNED : PS_HELD;
            ACT_OPEN: n = (cur == PS_PINNED && wp) ? PS_PINNED : PS_OPEN;
            ACT_PIN:  n = PS_PINNED;
            default:  n = cur;
        endcase
        return n;
    endfunction

endpackage

// File: rtl/blk_lock_seq.sv
module blk_lock_seq
    import blk_lock_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       wr_valid,
    input  logic [7:0] wr_data,
    output act_e       act,
    output logic [1:0] seq_err
);
    logic    armed_q;
    decode_t dec;

    always_comb begin
        dec = decode_second(wr_data);
        act = (wr_valid && armed_q) ? dec.act : ACT_NONE;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            armed_q <= 1'b0;
            seq_err <= 2'b00;
        end else begin
            seq_err <= (wr_valid && armed_q && dec.bad) ? 2'b11 : 2'b00;
            if (wr_valid) begin
                if (armed_q) armed_q <= 1'b0;
                else         armed_q <= (wr_data == CODE_ARM);
            end
        end
    end
endmodule

// File: rtl/blk_lock_cell.sv
module blk_lock_cell
    import blk_lock_pkg::*;
(
    input  logic  clk,
    input  logic  rst,
    input  logic  hit,
    input  act_e  act,
    input  logic  wp,
    output prot_e state
);
    always_ff @(posedge clk) begin
        if (rst)      state <= PS_HELD;
        else if (hit) state <= next_prot(state, act, wp);
    end
endmodule

// File: rtl/blk_lock_gate.sv
module blk_lock_gate #(
    parameter int N_BLK  = 8,
    parameter int IDX_W  = 4,
    parameter int STAT_W = 16
) (
    input  logic                   clk,
    input  logic                   rst,
    input  logic [N_BLK-1:0][1:0]  states,
    input  logic                   op_req,
    input  logic [IDX_W-1:0]       op_blk,
    output logic                   op_ok,
    output logic                   op_lock_err,
    input  logic [IDX_W-1:0]       rd_blk,
    output logic [STAT_W-1:0]      rd_status
);
    logic       op_in, rd_in;
    logic [1:0] op_st, rd_st;

    always_comb begin
        op_in = (int'(op_blk) < N_BLK);
        rd_in = (int'(rd_blk) < N_BLK);
        op_st = 2'b00;
        rd_st = 2'b00;
        for (int i = 0; i < N_BLK; i++) begin
            if (op_in && int'(op_blk) == i) op_st = states[i];
            if (rd_in && int'(rd_blk) == i) rd_st = states[i];
        end
        rd_status = '0;
        rd_status[1:0] = rd_st;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            op_ok       <= 1'b0;
            op_lock_err <= 1'b0;
        end else begin
            op_ok       <= op_req && op_in && (op_st == 2'b00);
            op_lock_err <= op_req && op_in && (op_st != 2'b00);
        end
    end
endmodule

// File: rtl/blk_lock_ctrl.sv
module blk_lock_ctrl
    import blk_lock_pkg::*;
#(
    parameter int N_BLK  = 8,
    parameter int IDX_W  = 4,
    parameter int STAT_W = 16
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_valid,
    input  logic [IDX_W-1:0]  wr_blk,
    input  logic [7:0]        wr_data,
    input  logic              wp,
    input  logic              op_req,
    input  logic [IDX_W-1:0]  op_blk,
    output logic              op_ok,
    output logic              op_lock_err,
    output logic [1:0]        seq_err,
    input  logic [IDX_W-1:0]  rd_blk,
    output logic [STAT_W-1:0] rd_status
);
    localparam int SLOTS = 1 << IDX_W;

    act_e                  act;
    logic                  wr_in;
    logic [N_BLK-1:0][1:0] states;

    initial begin
        if (N_BLK > SLOTS || STAT_W < 2)
            $error("blk_lock_ctrl: bad parameter set");
    end

    assign wr_in = (int'(wr_blk) < N_BLK);

    blk_lock_seq u_seq (
        .clk     (clk),
        .rst     (rst),
        .wr_valid(wr_valid),
        .wr_data (wr_data),
        .act     (act),
        .seq_err (seq_err)
    );

    for (genvar g = 0; g < N_BLK; g++) begin : g_cell
        prot_e st;
        logic  hit;
        assign hit = (act != ACT_NONE) && wr_in && (int'(wr_blk) == g);
        blk_lock_cell u_cell (
            .clk  (clk),
            .rst  (rst),
            .hit  (hit),
            .act  (act),
            .wp   (wp),
            .state(st)
        );
        assign states[g] = st;
    end

    blk_lock_gate #(
        .N_BLK (N_BLK),
        .IDX_W (IDX_W),
        .STAT_W(STAT_W)
    ) u_gate (
        .clk        (clk),
        .rst        (rst),
        .states     (states),
        .op_req     (op_req),
        .op_blk     (op_blk),
        .op_ok      (op_ok),
        .op_lock_err(op_lock_err),
        .rd_blk     (rd_blk),
        .rd_status  (rd_status)
    );
endmodule

// File: rtl/blk_lock_chk.sv
module blk_lock_chk #(
    parameter int N_BLK  = 8,
    parameter int IDX_W  = 4,
    parameter int STAT_W = 16
) (
    input logic              clk,
    input logic              rst,
    input logic              wr_valid,
    input logic              op_req,
    input logic [IDX_W-1:0]  op_blk,
    input logic              op_ok,
    input logic              op_lock_err,
    input logic [1:0]        seq_err,
    input logic [IDX_W-1:0]  rd_blk,
    input logic [STAT_W-1:0] rd_status
);
    // R1
    reset_held_chk: assert property (@(posedge clk) disable iff (rst)
        ($past(rst) && int'(rd_blk) < N_BLK) |-> rd_status == STAT_W'(1));
    // R7
    seq_err_src_chk: assert property (@(posedge clk) disable iff (rst)
        (seq_err != 2'b00) |-> ($past(wr_valid) && seq_err == 2'b11));
    // R8
    ok_src_chk: assert property (@(posedge clk) disable iff (rst)
        op_ok |-> $past(op_req));
    // R9
    lock_err_src_chk: assert property (@(posedge clk) disable iff (rst)
        op_lock_err |-> $past(op_req));
    // R9
    op_excl_chk: assert property (@(posedge clk) disable iff (rst)
        $countones({op_ok, op_lock_err}) <= 1);
    // R10
    status_shape_chk: assert property (@(posedge clk) disable iff (rst)
        (rd_status[STAT_W-1:2] == '0) && (!rd_status[1] || rd_status[0]));
    // R11
    range_op_chk: assert property (@(posedge clk) disable iff (rst)
        (op_ok || op_lock_err) |-> int'($past(op_blk)) < N_BLK);
    // R11
    range_rd_chk: assert property (@(posedge clk) disable iff (rst)
        (int'(rd_blk) >= N_BLK) |-> rd_status == '0);
endmodule

bind blk_lock_ctrl blk_lock_chk #(
    .N_BLK (N_BLK),
    .IDX_W (IDX_W),
    .STAT_W(STAT_W)
) u_chk (
    .clk        (clk),
    .rst        (rst),
    .wr_valid   (wr_valid),
    .op_req     (op_req),
    .op_blk     (op_blk),
    .op_ok      (op_ok),
    .op_lock_err(op_lock_err),
    .seq_err    (seq_err),
    .rd_blk     (rd_blk),
    .rd_status  (rd_status)
);

// File: tb/blk_lock_ctrl_tb.sv
module blk_lock_ctrl_tb;
    localparam int N  = 8;
    localparam int IW = 4;
    localparam int SW = 16;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          wr_valid = 1'b0;
    logic [IW-1:0] wr_blk = '0;
    logic [7:0]    wr_data = '0;
    logic          wp = 1'b1;
    logic          op_req = 1'b0;
    logic [IW-1:0] op_blk = '0;
    logic          op_ok, op_lock_err;
    logic [1:0]    seq_err;
    logic [IW-1:0] rd_blk = '0;
    logic [SW-1:0] rd_status;

    int   n_chk = 0;
    int   n_fail = 0;
    logic done = 1'b0;
    logic [1:0] exp_st [N];

    always #10 clk = ~clk;

    blk_lock_ctrl #(.N_BLK(N), .IDX_W(IW), .STAT_W(SW)) u_dut (
        .clk(clk), .rst(rst), .wr_valid(wr_valid), .wr_blk(wr_blk),
        .wr_data(wr_data), .wp(wp), .op_req(op_req), .op_blk(op_blk),
        .op_ok(op_ok), .op_lock_err(op_lock_err), .seq_err(seq_err),
        .rd_blk(rd_blk), .rd_status(rd_status)
    );

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
        end
    endtask

    function automatic logic [1:0] model(input logic [1:0] cur, input logic [7:0] code, input logic w);
        case (code)
            8'h01: return (cur == 2'b11) ? 2'b11 : 2'b01;
            8'hD0: return (cur == 2'b11 && w) ? 2'b11 : 2'b00;
            8'h2F: return 2'b11;
            default: return cur;
        endcase
    endfunction

    task automatic do_write(input int b, input logic [7:0] d);
        @(negedge clk);
        wr_valid = 1'b1;
        wr_blk   = IW'(b);
        wr_data  = d;
        @(negedge clk);
        wr_valid = 1'b0;
    endtask

    // R10, R11: read every index, including out-of-range ones
    task automatic check_all(input string req);
        for (int rb = 0; rb < (1 << IW); rb++) begin
            rd_blk = IW'(rb);
            #1;
            chk(rd_status == ((rb < N) ? SW'(exp_st[rb]) : SW'(0)), req,
                int'(rd_status), (rb < N) ? int'(exp_st[rb]) : 0);
        end
    endtask

    // R8, R9, R11
    task automatic do_op(input int b);
        logic eok, eerr;
        @(negedge clk);
        op_req = 1'b1;
        op_blk = IW'(b);
        @(negedge clk);
        op_req = 1'b0;
        eok  = (b < N) && (exp_st[b] == 2'b00);
        eerr = (b < N) && (exp_st[b] != 2'b00);
        chk(op_ok == eok, "R8 grant", int'(op_ok), int'(eok));
        chk(op_lock_err == eerr, "R9 lock error", int'(op_lock_err), int'(eerr));
    endtask

    task automatic do_reset();
        rst = 1'b1;
        repeat (2) @(negedge clk);
        rst = 1'b0;
        for (int i = 0; i < N; i++) exp_st[i] = 2'b01;
    endtask

    initial begin
        logic [7:0] codes [10];
        logic [7:0] noise;
        logic       bad;
        codes = '{8'h01, 8'hD0, 8'h2F, 8'h00, 8'hD0, 8'h60, 8'h01, 8'hFF, 8'hD0, 8'h50};
        do_reset();
        @(negedge clk);
        check_all("R1 reset state");
        chk(seq_err == 2'b00, "R7 idle error", int'(seq_err), 0);
        for (int b = 0; b < N + 2; b++) do_op(b);

        for (int w = 1; w >= 0; w--) begin
            wp = w[0];
            for (int c = 0; c < 10; c++) begin
                for (int b = 0; b < N + 2; b++) begin
                    // R2: idle write without setup has no effect
                    noise = (codes[c] == 8'h60) ? 8'h70 : codes[c];
                    do_write(b, noise);
                    chk(seq_err == 2'b00, "R2 idle write error", int'(seq_err), 0);
                    check_all("R2 idle write state");
                    // R2: setup index ignored, second cycle decides
                    do_write((b + 3) % (1 << IW), 8'h60);
                    do_write(b, codes[c]);
                    bad = !(codes[c] == 8'h01 || codes[c] == 8'hD0 || codes[c] == 8'h2F);
                    if (b < N) exp_st[b] = model(exp_st[b], codes[c], wp);
                    // R7, R11
                    chk(seq_err == (bad ? 2'b11 : 2'b00), "R7 sequence error",
                        int'(seq_err), bad ? 3 : 0);
                    @(negedge clk);
                    chk(seq_err == 2'b00, "R7 error one cycle", int'(seq_err), 0);
                    // R3 R4 R5 R6 state readback
                    check_all("R3/R4/R5/R6 state");
                    do_op(b);
                end
            end
        end

        // R6: pin block 2, then reset clears it (R1)
        wp = 1'b1;
        do_write(0, 8'h60);
        do_write(2, 8'h2F);
        exp_st[2] = 2'b11;
        check_all("R6 pin");
        do_reset();
        @(negedge clk);
        check_all("R1 reset clears pin");
        do_write(0, 8'h60);
        do_write(2, 8'hD0);
        exp_st[2] = 2'b00;
        check_all("R4 unlock after reset");
        do_op(2);

        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end
endmodule